// File: doc/BRIEF.md
# Two-Wire Bus Slave Byte Engine

This block is the slave-side front end of a two-wire open-drain serial bus that has one clock line and one data line. A faster system clock samples both lines after a two-stage synchronizer. The block finds start and stop conditions by watching the data line while the bus clock is high. It keeps a bus-busy flag. That flag clears on a stop, or when both lines have stayed high for longer than an idle timeout set by parameters.

Inside a transaction the block counts bus clock pulses in groups of nine. In receive mode it shifts in eight data bits with the most significant bit first, strobes the finished byte, and then acknowledges or refuses the byte in the ninth slot. In transmit mode it shifts a byte out on the data line and then releases the line so the master can answer in the ninth slot. The master's answer is reported on a status output. The data line is driven as an open-drain enable, where 1 means pull low. The enable changes only after a falling bus-clock edge has been detected. Address decoding and clock stretching belong to the logic that surrounds this block.

Top module: `twb_slave`

## Requirements
- R1: A falling data line while the synchronized clock line is high gives exactly one `start_o` pulse, and `busy_o` is 1 in that same cycle and stays 1 afterwards.
- R2: A rising data line while the clock line is high gives exactly one `stop_o` pulse, and `busy_o` is 0 from that cycle on.
- R3: `busy_o` clears after both synchronized lines have been high for IDLE_CYC consecutive cycles, where IDLE_CYC = CLK_FREQ_HZ/1e6 × IDLE_US. A low level on either line restarts the count. A timeout gives no `stop_o` pulse.
- R4: In receive mode, data is sampled on each rising clock edge, with the most significant bit first. After the eighth falling edge the block raises `rx_valid_o` for one cycle and presents the eight bits on `rx_byte_o`.
- R5: `ack_en_i` is sampled at the eighth falling edge. When it is 1, `sda_oe_o` is 1 (pull low) for the whole ninth clock pulse. When it is 0, the line is left released, which is a not-acknowledge.
- R6: `sda_oe_o` changes only while the synchronized clock line is low.
- R7: The first byte after any start is always received, whatever the value of `tx_mode_i`.
- R8: If `tx_mode_i` is 1 at the falling edge that ends a ninth slot, the next byte is taken from `tx_byte_i`. It is sent most significant bit first, with `sda_oe_o` equal to the inverse of each bit. The line is released in the ninth slot, and a transmitted byte raises no `rx_valid_o`.
- R9: At the ninth rising edge of a transmitted byte, `mack_valid_o` pulses once. `mack_ack_o` is 1 if the line was low (master acknowledged) and 0 if it was high.
- R10: After the master refuses a transmitted byte, the block stops transmitting. The next byte is received even when `tx_mode_i` is still 1.
- R11: A start in the middle of a byte (repeated start) resets the bit count. The partial bits are discarded and the next eight bits form a fresh byte.
- R12: A stop in the middle of a byte aborts it, and no `rx_valid_o` pulse follows.
- R13: Clock pulses while the bus is not busy are ignored: there is no `rx_valid_o` pulse and `sda_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Data line pull-down enable (1 = drive low) |
| tx_mode_i | input | 1 | Transmit the next byte when set at the end of an acknowledge slot |
| tx_byte_i | input | BITS | Byte to transmit, loaded at the end of an acknowledge slot |
| ack_en_i | input | 1 | Acknowledge the byte being received (0 = not-acknowledge) |
| rx_valid_o | output | 1 | One-cycle strobe for a completed received byte |
| rx_byte_o | output | BITS | Last received byte |
| start_o | output | 1 | One-cycle pulse on a start condition |
| stop_o | output | 1 | One-cycle pulse on a stop condition |
| busy_o | output | 1 | Bus busy flag |
| mack_valid_o | output | 1 | One-cycle pulse when the master's acknowledge bit is captured |
| mack_ack_o | output | 1 | Master's answer: 1 = acknowledged, 0 = refused |

## Verification
The bench writes all 256 byte values in one transaction, with a mix of acknowledge and not-acknowledge. A design that shifted the bits in the wrong order, or counted the falling edge right after a start as a bit, would return rotated or shifted bytes. A design that held its acknowledge for only part of the ninth pulse would show a high sample in that slot. A transmit sequence ends with a master refusal. A block that kept driving after the refusal would corrupt the byte that follows. A receiver that missed a repeated start or a stop would report a bogus byte built from partial bits. The idle-timeout test breaks the high period partway through. A counter that does not restart on a low level frees the bus too early, and one that reports the timeout as a stop adds a `stop_o` pulse.

// File: rtl/twb_pkg.sv
package twb_pkg;

    // Bus events derived from the synchronized line samples
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic timeout;
    } bus_evt_t;

endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
    parameter int WIDTH   = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        typedef struct packed {
            logic meta;
            logic stab;
        } sync_t;

        sync_t st_d, st_q;

        always_comb begin
            st_d.meta = d_i[g];
            st_d.stab = st_q.meta;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '{meta: RST_VAL, stab: RST_VAL};
            end else begin
                st_q <= st_d;
            end
        end

        assign q_o[g] = st_q.stab;
    end

endmodule

// File: rtl/twb_cond.sv
module twb_cond
    import twb_pkg::*;
#(
    parameter int IDLE_CYC = 5000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt_o,
    output logic     busy_o,
    output logic     start_o,
    output logic     stop_o
);

    localparam int            IW       = $clog2(IDLE_CYC + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYC);

    typedef struct packed {
        logic          scl_p;
        logic          sda_p;
        logic [IW-1:0] idle;
        logic          busy;
        logic          start;
        logic          stop;
    } cond_t;

    cond_t st_d, st_q;
    logic  start_c, stop_c, rise_c, fall_c, timeout_c;

    always_comb begin
        start_c   = scl_s && st_q.scl_p && st_q.sda_p && !sda_s;
        stop_c    = scl_s && st_q.scl_p && !st_q.sda_p && sda_s;
        rise_c    = scl_s && !st_q.scl_p;
        fall_c    = !scl_s && st_q.scl_p;
        timeout_c = st_q.busy && (st_q.idle == IDLE_MAX);

        st_d       = st_q;
        st_d.scl_p = scl_s;
        st_d.sda_p = sda_s;
        st_d.start = start_c;
        st_d.stop  = stop_c;

        if (scl_s && sda_s) begin
            if (st_q.idle != IDLE_MAX) begin
                st_d.idle = st_q.idle + 1'b1;
            end
        end else begin
            st_d.idle = '0;
        end

        if (start_c) begin
            st_d.busy = 1'b1;
        end else if (stop_c || timeout_c) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl_p: 1'b1, sda_p: 1'b1, idle: '0, busy: 1'b0,
                      start: 1'b0, stop: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        evt_o.start    = start_c;
        evt_o.stop     = stop_c;
        evt_o.scl_rise = rise_c;
        evt_o.scl_fall = fall_c;
        evt_o.timeout  = timeout_c;
    end

    assign busy_o  = st_q.busy;
    assign start_o = st_q.start;
    assign stop_o  = st_q.stop;

    // R3
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(stop_c || (st_q.idle == IDLE_MAX)));

    // R3
    idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idle <= IDLE_MAX);

endmodule

// File: rtl/twb_byte.sv
module twb_byte
    import twb_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_evt_t        evt_i,
    input  logic            sda_s,
    input  logic            tx_mode_i,
    input  logic [BITS-1:0] tx_byte_i,
    input  logic            ack_en_i,
    output logic            sda_oe_o,
    output logic            rx_valid_o,
    output logic [BITS-1:0] rx_byte_o,
    output logic            mack_valid_o,
    output logic            mack_ack_o
);

    localparam int            CW   = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);
    localparam logic [CW-1:0] FULL = CW'(BITS);

    typedef struct packed {
        logic            active;
        logic            seen_rise;
        logic            tx;
        logic [CW-1:0]   cnt;
        logic [BITS-1:0] shreg;
        logic            oe;
        logic            rx_valid;
        logic [BITS-1:0] rx_byte;
        logic            mack_valid;
        logic            mack_ack;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.rx_valid   = 1'b0;
        st_d.mack_valid = 1'b0;

        if (evt_i.start) begin
            st_d.active    = 1'b1;
            st_d.seen_rise = 1'b0;
            st_d.tx        = 1'b0;
            st_d.cnt       = '0;
            st_d.oe        = 1'b0;
        end else if (evt_i.stop || evt_i.timeout) begin
            st_d.active    = 1'b0;
            st_d.seen_rise = 1'b0;
            st_d.tx        = 1'b0;
            st_d.cnt       = '0;
            st_d.oe        = 1'b0;
        end else if (st_q.active) begin
            if (evt_i.scl_rise) begin
                st_d.seen_rise = 1'b1;
                if (st_q.cnt < FULL) begin
                    if (!st_q.tx) begin
                        st_d.shreg = {st_q.shreg[BITS-2:0], sda_s};
                    end
                end else if (st_q.tx) begin
                    st_d.mack_valid = 1'b1;
                    st_d.mack_ack   = !sda_s;
                end
            end else if (evt_i.scl_fall && st_q.seen_rise) begin
                st_d.seen_rise = 1'b0;
                if (st_q.cnt < LAST) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.tx) begin
                        st_d.shreg = st_q.shreg << 1;
                        st_d.oe    = !st_q.shreg[BITS-2];
                    end
                end else if (st_q.cnt == LAST) begin
                    st_d.cnt = FULL;
                    if (st_q.tx) begin
                        st_d.oe = 1'b0;
                    end else begin
                        st_d.rx_valid = 1'b1;
                        st_d.rx_byte  = st_q.shreg;
                        st_d.oe       = ack_en_i;
                    end
                end else begin
                    st_d.cnt = '0;
                    if (tx_mode_i && (!st_q.tx || st_q.mack_ack)) begin
                        st_d.tx    = 1'b1;
                        st_d.shreg = tx_byte_i;
                        st_d.oe    = !tx_byte_i[BITS-1];
                    end else begin
                        st_d.tx = 1'b0;
                        st_d.oe = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o     = st_q.oe;
    assign rx_valid_o   = st_q.rx_valid;
    assign rx_byte_o    = st_q.rx_byte;
    assign mack_valid_o = st_q.mack_valid;
    assign mack_ack_o   = st_q.mack_ack;

    // R4
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    // R8
    rx_not_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_valid |-> !st_q.tx);

    // R9
    mack_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mack_valid |-> st_q.tx);

endmodule

// File: rtl/twb_slave.sv
module twb_slave
    import twb_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int IDLE_US     = 50,
    parameter int BITS        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe_o,
    input  logic            tx_mode_i,
    input  logic [BITS-1:0] tx_byte_i,
    input  logic            ack_en_i,
    output logic            rx_valid_o,
    output logic [BITS-1:0] rx_byte_o,
    output logic            start_o,
    output logic            stop_o,
    output logic            busy_o,
    output logic            mack_valid_o,
    output logic            mack_ack_o
);

    localparam int IDLE_CYC = (CLK_FREQ_HZ / 1_000_000) * IDLE_US;

    logic [1:0] line_raw, line_syn;
    logic       scl_s, sda_s;
    bus_evt_t   evt;

    assign line_raw = {scl_i, sda_i};
    assign scl_s    = line_syn[1];
    assign sda_s    = line_syn[0];

    twb_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_raw),
        .q_o   (line_syn)
    );

    twb_cond #(.IDLE_CYC(IDLE_CYC)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .evt_o   (evt),
        .busy_o  (busy_o),
        .start_o (start_o),
        .stop_o  (stop_o)
    );

    twb_byte #(.BITS(BITS)) u_byte (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .sda_s        (sda_s),
        .tx_mode_i    (tx_mode_i),
        .tx_byte_i    (tx_byte_i),
        .ack_en_i     (ack_en_i),
        .sda_oe_o     (sda_oe_o),
        .rx_valid_o   (rx_valid_o),
        .rx_byte_o    (rx_byte_o),
        .mack_valid_o (mack_valid_o),
        .mack_ack_o   (mack_ack_o)
    );

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    // R2
    stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !busy_o);

    // R6
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

    // R13
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sda_oe_o);

endmodule

// File: tb/tb_twb_slave.sv
module tb_twb_slave;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       tx_mode = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       ack_en = 1'b1;
    logic       sda_oe, rx_valid, start_p, stop_p, busy, mack_valid, mack_ack;
    logic [7:0] rx_byte;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    twb_slave #(.CLK_FREQ_HZ(1_000_000), .IDLE_US(50), .BITS(8)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .tx_mode_i    (tx_mode),
        .tx_byte_i    (tx_byte),
        .ack_en_i     (ack_en),
        .rx_valid_o   (rx_valid),
        .rx_byte_o    (rx_byte),
        .start_o      (start_p),
        .stop_o       (stop_p),
        .busy_o       (busy),
        .mack_valid_o (mack_valid),
        .mack_ack_o   (mack_ack)
    );

    int n_checks = 0;
    int n_errors = 0;
    int n_start = 0, n_stop = 0, n_rx = 0, n_mack = 0;
    logic [7:0] last_rx = 8'h00;
    logic       last_mack = 1'b0;
    bit         done = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (start_p)    n_start++;
            if (stop_p)     n_stop++;
            if (rx_valid)   begin n_rx++; last_rx = rx_byte; end
            if (mack_valid) begin n_mack++; last_mack = mack_ack; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic drive_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q();
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] v, output logic all_low, output logic all_high);
        for (int i = 7; i >= 0; i--) drive_bit(v[i]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1;
        all_low = 1'b1; all_high = 1'b1;
        repeat (Q) begin
            @(negedge clk);
            if (sda_line) all_low = 1'b0; else all_high = 1'b0;
        end
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic [7:0] nxt, input logic give_ack, output logic [7:0] v);
        v = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wait_q();
            scl_m = 1'b1;
            repeat (Q / 2) @(negedge clk);
            v[i] = sda_line;
            repeat (Q - Q / 2) @(negedge clk);
            scl_m = 1'b0;
        end
        tx_byte = nxt;
        sda_m = ~give_ack; wait_q();
        scl_m = 1'b1; wait_q();
        scl_m = 1'b0;
    endtask

    function automatic logic [7:0] tx_val(input int k);
        return 8'((k * 37 + 11) & 8'hFF);
    endfunction

    initial begin
        logic lo, hi;
        logic [7:0] rv;
        int base_rx, base_start, base_stop, base_mack;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(sda_oe == 1'b0, "R13 reset oe", sda_oe, 0);
        check(n_rx == 0 && n_start == 0, "R4 reset strobes", n_rx + n_start, 0);

        // R1: start sets busy; R4/R5 sweep of all byte values with mixed ack
        bus_start();
        check(n_start == 1, "R1 start pulse", n_start, 1);
        check(busy == 1'b1, "R1 busy after start", busy, 1);
        for (int b = 0; b < 256; b++) begin
            ack_en = b[0] ^ b[5];
            write_byte(8'(b), lo, hi);
            check(n_rx == b + 1, "R4 rx strobe count", n_rx, b + 1);
            check(last_rx == 8'(b), "R4 rx byte msb first", last_rx, b);
            if (ack_en) check(lo == 1'b1, "R5 ack held low whole pulse", lo, 1);
            else        check(hi == 1'b1, "R5 nak line released", hi, 1);
        end
        check(n_start == 1, "R1 no spurious start", n_start, 1);
        check(n_stop == 0, "R2 no spurious stop", n_stop, 0);
        bus_stop();
        check(n_stop == 1, "R2 stop pulse", n_stop, 1);
        check(busy == 1'b0, "R2 busy cleared by stop", busy, 0);

        // R7, R8, R9, R10: transmit sequence
        ack_en = 1'b1;
        tx_mode = 1'b1;
        tx_byte = tx_val(0);
        base_rx = n_rx;
        bus_start();
        write_byte(8'hA2, lo, hi);
        check(n_rx == base_rx + 1 && last_rx == 8'hA2, "R7 first byte received", last_rx, 8'hA2);
        check(lo == 1'b1, "R7 address acked", lo, 1);
        base_mack = n_mack;
        for (int k = 0; k < 16; k++) begin
            read_byte(tx_val(k + 1), (k < 15), rv);
            check(rv == tx_val(k), "R8 transmitted byte", rv, tx_val(k));
            check(n_mack == base_mack + k + 1, "R9 mack strobe", n_mack, base_mack + k + 1);
            check(last_mack == (k < 15), "R9 mack value", last_mack, (k < 15));
        end
        check(n_rx == base_rx + 1, "R8 no rx strobe while sending", n_rx, base_rx + 1);
        ack_en = 1'b0;
        read_byte(8'h00, 1'b0, rv);
        check(rv == 8'hFF, "R10 released after master nak", rv, 8'hFF);
        check(n_rx == base_rx + 2 && last_rx == 8'hFF, "R10 next byte received", last_rx, 8'hFF);
        tx_mode = 1'b0;
        ack_en = 1'b1;
        bus_stop();

        // R11: repeated start in the middle of a byte
        base_rx = n_rx; base_start = n_start;
        bus_start();
        drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
        check(n_start == base_start + 2, "R11 repeated start seen", n_start, base_start + 2);
        check(n_rx == base_rx, "R11 partial bits dropped", n_rx, base_rx);
        write_byte(8'h5A, lo, hi);
        check(n_rx == base_rx + 1 && last_rx == 8'h5A, "R11 fresh byte", last_rx, 8'h5A);

        // R12: stop in the middle of a byte
        base_stop = n_stop;
        drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1);
        bus_stop();
        repeat (10) @(negedge clk);
        check(n_rx == base_rx + 1, "R12 abort without strobe", n_rx, base_rx + 1);
        check(n_stop == base_stop + 1 && busy == 1'b0, "R12 stop frees bus", n_stop, base_stop + 1);

        // R3: idle timeout with an interrupted high period
        base_stop = n_stop;
        bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1;
        repeat (30) @(negedge clk);
        check(busy == 1'b1, "R3 busy before timeout", busy, 1);
        scl_m = 1'b0; wait_q();
        scl_m = 1'b1;
        repeat (40) @(negedge clk);
        check(busy == 1'b1, "R3 low level restarts count", busy, 1);
        repeat (30) @(negedge clk);
        check(busy == 1'b0, "R3 busy cleared by timeout", busy, 0);
        check(n_stop == base_stop, "R3 no stop pulse on timeout", n_stop, base_stop);

        // R13: clocking without a start is ignored
        base_rx = n_rx;
        ack_en = 1'b1;
        scl_m = 1'b0; wait_q();
        write_byte(8'h3C, lo, hi);
        check(n_rx == base_rx, "R13 no strobe when free", n_rx, base_rx);
        check(hi == 1'b1, "R13 line released when free", hi, 1);
        scl_m = 1'b1; wait_q();
        repeat (10) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule